// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver

This block takes one asynchronous serial line and turns each frame into a byte. A frame is a low start bit, eight data bits with the least significant bit first, an optional parity bit and one high stop bit. The line is resynchronised into the clock domain and then sampled on an oversampling tick that is supplied from outside. The block counts ticks to find the middle of each bit.

Each completed byte is placed in a holding register and marks it full. A one-cycle completion pulse accompanies every finished frame. Parity, framing and overrun conditions are reported as flags. A single read strobe empties the holding register and clears all three flags. Reception runs only while both the power enable and the receive enable are high.

Top module: `async_rx_frame`

## Requirements
- R1: While `pwr_en_i` or `rx_en_i` is low, no frame is received and `done_o` stays low. Clearing either enable in the middle of a frame drops that frame: no completion is raised for it.
- R2: A frame starts only on a falling edge of the line after the line has been seen high. A line held low from reset never starts a frame.
- R3: If the line is back high at the middle of the start bit (8 ticks after the falling edge), the frame is abandoned and the receiver waits for the next falling edge.
- R4: The receiver samples one bit every 16 ticks after the start check, and data arrives least significant bit first. When the stop bit is sampled, the byte appears on `data_o` and `valid_o` goes high. In the same clock edge, `done_o` pulses high for exactly one cycle.
- R5: `par_mode_i` selects the parity bit: 0 means no parity bit, 1 means even, 2 means odd and 3 means the bit must be zero. For even parity the received bit must equal the XOR of the data bits; for odd parity it must equal the inverse of that XOR. A mismatch sets `perr_o`, and the frame still completes.
- R6: A stop bit sampled low sets `ferr_o`. The byte is still stored and `done_o` still pulses.
- R7: If a frame completes while `valid_o` is high and no read is presented in that cycle, the new frame is discarded and `oerr_o` is set. `data_o` keeps the old byte, the parity and framing flags are not updated, and `done_o` still pulses.
- R8: `rd_i` clears `valid_o`, `perr_o`, `ferr_o` and `oerr_o`. A read in the same cycle as a completion lets the new byte be stored without an overrun.
- R9: Only one stop bit is checked. A start bit that follows the stop bit at once is received correctly, and extra high time after the stop bit is treated as idle line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oversampling tick, 16 per bit period |
| rx_i | input | 1 | Serial line, asynchronous |
| pwr_en_i | input | 1 | Power enable |
| rx_en_i | input | 1 | Receive enable |
| par_mode_i | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 zero |
| rd_i | input | 1 | Read strobe for the holding register |
| data_o | output | DW | Received byte |
| valid_o | output | 1 | Holding register full |
| done_o | output | 1 | One-cycle frame completion pulse |
| perr_o | output | 1 | Parity error flag |
| ferr_o | output | 1 | Framing error flag |
| oerr_o | output | 1 | Overrun error flag |

## Verification
The bench uses the default 16x oversampling and an 8-bit data width, with a tick every fourth clock, so one bit lasts 64 clocks. This leaves roughly 30 clocks of margin around each mid-bit sample. That margin lets the bench drive frames back to back, drop an enable partway through a frame, and inject a start glitch shorter than half a bit. All four parity modes are drawn at random, together with corrupted parity bits. Directed cases cover a stop bit driven low, an unread byte followed by a second frame, and a line held low from reset.

// File: rtl/async_rx_frame.sv
module async_rx_frame #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          rx_i,
  input  logic          pwr_en_i,
  input  logic          rx_en_i,
  input  logic [1:0]    par_mode_i,
  input  logic          rd_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          done_o,
  output logic          perr_o,
  output logic          ferr_o,
  output logic          oerr_o
);
  localparam int CW   = $clog2(OSR);
  localparam int BW   = $clog2(DW);
  localparam int HALF = OSR / 2;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic          rx_m, rx_s, rx_d;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bit_idx;
  logic [DW-1:0] shreg;
  logic          par_bad;
  logic          par_exp;

  wire active  = pwr_en_i & rx_en_i;
  wire fall    = rx_d & ~rx_s;
  wire mid_st  = tick_i && (cnt == CW'(HALF - 1));
  wire bit_end = tick_i && (cnt == CW'(OSR - 1));
  wire keep    = valid_o & ~rd_i;

  always_comb begin
    case (par_mode_i)
      2'd1:    par_exp = ^shreg;
      2'd2:    par_exp = ~^shreg;
      default: par_exp = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b0;
      rx_s <= 1'b0;
      rx_d <= 1'b0;
    end else begin
      rx_m <= rx_i;
      rx_s <= rx_m;
      rx_d <= rx_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      par_bad <= 1'b0;
      data_o  <= '0;
      valid_o <= 1'b0;
      done_o  <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
      oerr_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (rd_i) begin
        valid_o <= 1'b0;
        perr_o  <= 1'b0;
        ferr_o  <= 1'b0;
        oerr_o  <= 1'b0;
      end
      if (!active) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: st <= S_WAIT;
          S_WAIT: if (fall) begin
            st  <= S_START;
            cnt <= '0;
          end
          S_START: if (tick_i) begin
            if (mid_st) begin
              cnt     <= '0;
              bit_idx <= '0;
              par_bad <= 1'b0;
              st      <= rx_s ? S_WAIT : S_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: if (tick_i) begin
            cnt <= cnt + 1'b1;
            if (bit_end) begin
              shreg <= {rx_s, shreg[DW-1:1]};
              if (bit_idx == BW'(DW - 1))
                st <= (par_mode_i == 2'd0) ? S_STOP : S_PAR;
              else
                bit_idx <= bit_idx + 1'b1;
            end
          end
          S_PAR: if (tick_i) begin
            cnt <= cnt + 1'b1;
            if (bit_end) begin
              par_bad <= (rx_s != par_exp);
              st      <= S_STOP;
            end
          end
          S_STOP: if (tick_i) begin
            cnt <= cnt + 1'b1;
            if (bit_end) begin
              done_o <= 1'b1;
              st     <= S_WAIT;
              if (keep) begin
                oerr_o <= 1'b1;
              end else begin
                data_o  <= shreg;
                valid_o <= 1'b1;
                perr_o  <= par_bad;
                ferr_o  <= ~rx_s;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r1_off_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_en_i && rx_en_i) |=> !done_o);
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r4_done_full: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> valid_o);
  a_r7_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oerr_o) |-> $stable(data_o));
  a_r8_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> (!valid_o || done_o));
  a_r8_read_flags: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> (!oerr_o && (!perr_o || done_o) && (!ferr_o || done_o)));
endmodule

// File: tb/async_rx_frame_bench.sv
module async_rx_frame_bench;
  localparam int TDIV = 4;
  localparam int BITC = 16 * TDIV;

  logic clk = 0, rst_n = 0, tick = 0, rx = 0, pwr = 0, ren = 0, rd = 0;
  logic [1:0] pmode = 0;
  logic [7:0] data;
  logic valid, done, perr, ferr, oerr;
  int n_chk = 0, n_bad = 0, n_done = 0, tdiv = 0;
  bit finished = 0;

  async_rx_frame u_async_rx_frame (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx), .pwr_en_i(pwr),
    .rx_en_i(ren), .par_mode_i(pmode), .rd_i(rd), .data_o(data),
    .valid_o(valid), .done_o(done), .perr_o(perr), .ferr_o(ferr), .oerr_o(oerr));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= (tdiv == TDIV - 1) ? 0 : tdiv + 1;
    tick <= (tdiv == TDIV - 1);
  end

  always @(negedge clk) if (done) n_done++;

  function automatic bit par_of(input logic [1:0] m, input logic [7:0] d);
    case (m)
      2'd1: return ^d;
      2'd2: return ~^d;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic drive_bit(input bit b);
    @(negedge clk) rx = b;
    repeat (BITC - 1) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit flip, input bit stop_v, input int idle);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (pmode != 2'd0) drive_bit(par_of(pmode, d) ^ flip);
    drive_bit(stop_v);
    @(negedge clk) rx = 1'b1;
    repeat (idle) @(negedge clk);
  endtask

  task automatic read();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int base;
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset valid", valid, 0);
    chk("reset flags", {perr, ferr, oerr, done}, 0);
    pwr = 1;
    @(negedge clk) ren = 1;

    // R2: line low since reset never starts a frame
    repeat (400) @(negedge clk);
    chk("R2 low line no frame", n_done, 0);
    rx = 1;
    repeat (100) @(negedge clk);

    // R4: basic frame, no parity
    send(8'hA5, 0, 1, 40);
    chk("R4 done count", n_done, 1);
    chk("R4 data", data, 8'hA5);
    chk("R4 valid", valid, 1);
    chk("R4 no errors", {perr, ferr, oerr}, 0);
    read();
    chk("R8 read clears valid", valid, 0);

    // R3: short low glitch rejected at mid start
    @(negedge clk) rx = 0;
    repeat (12) @(negedge clk);
    rx = 1;
    repeat (1500) @(negedge clk);
    chk("R3 glitch no frame", n_done, 1);

    // R1: receive enable low ignores frame
    ren = 0;
    send(8'h3C, 0, 1, 40);
    chk("R1 disabled no frame", n_done, 1);
    chk("R1 disabled valid", valid, 0);
    ren = 1;
    // R1: power drop mid-frame drops partial frame
    drive_bit(0); drive_bit(1); drive_bit(0);
    @(negedge clk) pwr = 0;
    repeat (5) @(negedge clk);
    pwr = 1;
    rx = 1;
    repeat (300) @(negedge clk);
    chk("R1 aborted frame", n_done, 1);
    send(8'h5A, 0, 1, 40);
    chk("R1 resumes data", data, 8'h5A);
    read();

    // R6: framing error still completes
    base = n_done;
    send(8'hC3, 0, 0, 60);
    chk("R6 done", n_done, base + 1);
    chk("R6 ferr", ferr, 1);
    chk("R6 data kept", data, 8'hC3);
    read();
    chk("R8 read clears ferr", ferr, 0);

    // R5: fixed-zero parity given a one
    pmode = 2'd3;
    send(8'h81, 1, 1, 40);
    chk("R5 zero mode perr", perr, 1);
    chk("R5 zero mode data", data, 8'h81);
    read();
    chk("R8 read clears perr", perr, 0);

    // R7: overrun keeps old byte
    pmode = 2'd1;
    base = n_done;
    send(8'h11, 0, 1, 40);
    send(8'h22, 1, 0, 40);
    chk("R7 both done", n_done, base + 2);
    chk("R7 oerr", oerr, 1);
    chk("R7 old data", data, 8'h11);
    chk("R7 flags untouched", {perr, ferr}, 0);
    read();
    chk("R8 read clears oerr", {oerr, valid}, 0);

    // R9: back-to-back frames, single stop bit
    pmode = 2'd0;
    base = n_done;
    send(8'h0F, 0, 1, 0);
    send(8'hF0, 0, 1, 40);
    chk("R9 back-to-back done", n_done, base + 2);
    chk("R9 first kept", data, 8'h0F);
    read();

    // R5/R4: random frames across parity modes
    for (int k = 0; k < 20; k++) begin
      logic [7:0] d;
      bit flip;
      d = 8'($urandom);
      pmode = 2'($urandom);
      flip = ($urandom % 3) == 0;
      base = n_done;
      send(d, flip, 1, 20 + ($urandom % 40));
      chk("R4 random done", n_done, base + 1);
      chk("R4 random data", data, d);
      chk("R5 random perr", perr, (pmode != 0) && flip);
      chk("R6 random ferr", ferr, 0);
      read();
    end
    report();
  end
endmodule